// File: doc/BRIEF.md
# Redundant Power Stage Health Monitor

This block generates the gate enables for a pair of boost power stages. Each stage has two series transistors on its high side and two on its low side. Only one stage runs at a time; the other is held as a spare. In service, the active stage switches its middle (inner) transistors and keeps the rail-side (outer) transistors fully on. On a programmable schedule, counted in switching periods, the block opens a test window. In that window the roles swap: the outer pair switches and the inner pair is held on. A stuck or shorted device then shows up as a change in the measured peak current.

The block keeps two sets of peak-current samples, one for each mode, and works out a short moving mean of each. At the close of every test window it compares the two means. If they differ by more than a threshold, the active stage is marked failed and its gates are forced off, and the spare takes over. The fault is sticky. It reports a status bit and the index of the stage that failed first, and it stays set until an explicit clear. Every change of role passes through one switching period in which all eight gates are off.

Top module: `rps_health_mon`

## Requirements
- R1: After reset, stage 0 is active in normal mode, `fault_o`=0 and `active_stage_o`=0. With `pwm_i`=1, `gate_o` is 8'h0B.
- R2: Gate bit mapping within stage s: bit 4s+0 is high outer, 4s+1 is high inner, 4s+2 is low inner, 4s+3 is low outer. In normal mode the active stage drives both outer bits high, high inner = `pwm_i` and low inner = !`pwm_i`. The gates of the inactive stage are all 0.
- R3: In test mode the active stage drives both inner bits high, high outer = `pwm_i` and low outer = !`pwm_i`.
- R4: Periods are counted on `period_start_i` pulses. The sequence is: normal for `test_interval_i` periods, one blank period, test for `test_len_i` periods, one blank period, then normal again. Both lengths must be at least 4.
- R5: During a blank period all eight gate enables are 0.
- R6: Each mode keeps the mean of its last 4 samples. A sample is taken when `cur_valid_i`=1, and the current mode selects which set it goes to. Samples that arrive in a blank period are ignored.
- R7: At the period pulse that ends a test window, a fault trips if |normal mean − test mean| > `fault_thr_i`. A difference equal to the threshold does not trip.
- R8: On a trip, `fault_o` rises and, if no fault was already set, `failed_stage_o` records the failing stage. `active_stage_o` toggles, both sample sets are cleared, and the following period is blank.
- R9: A failed stage stays off until `fault_clr_i`. If both stages have failed, all gates are 0. The clear drops `fault_o` and keeps the active stage as it is.
- R10: Within one stage, the high-side path (both high bits) and the low-side path (both low bits) are never on together. At most one stage has any gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_start_i | input | 1 | One-cycle pulse at the start of each switching period |
| pwm_i | input | 1 | PWM phase: 1 = high side conducts |
| cur_valid_i | input | 1 | Peak-current sample strobe |
| cur_peak_i | input | CUR_W | Peak-current sample |
| test_interval_i | input | CNT_W | Normal periods between test windows |
| test_len_i | input | CNT_W | Periods per test window |
| fault_thr_i | input | CUR_W | Allowed difference of the two means |
| fault_clr_i | input | 1 | Clears all stage failures |
| gate_o | output | 8 | Gate enables, 4 per stage |
| fault_o | output | 1 | Sticky fault status |
| failed_stage_o | output | 1 | Index of the first failed stage |
| active_stage_o | output | 1 | Index of the stage in service |

## Verification
A wrong mode or a wrong period count shows up within the same period as a wrong gate pattern, because the gates are decoded combinationally from the mode and `pwm_i`. A corrupted sample set shows up only at the end of the next test window, as a trip that should not happen or a trip that is missed. To make this visible, the bench feeds constant normal and test levels exactly at the threshold and one step above it. It also drives huge samples during blank periods: if those were taken into the means, the bench would see a false failover at the close of the window.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    ST_NORM    = 2'd0,
    ST_GAP_IN  = 2'd1,
    ST_TEST    = 2'd2,
    ST_GAP_OUT = 2'd3
  } rps_mode_e;
endpackage

// File: rtl/rps_sched.sv
module rps_sched
  import rps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [CNT_W-1:0] len_i,
  output rps_mode_e        mode_o,
  output logic             test_end_o
);
  rps_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last       = (mode_q == ST_NORM) ? (cnt_q == interval_i - CNT_W'(1))
                                          : (cnt_q == len_i - CNT_W'(1));
  assign test_end_o = tick_i && (mode_q == ST_TEST) && last;
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ST_NORM;
      cnt_q  <= '0;
    end else if (tick_i) begin
      unique case (mode_q)
        ST_NORM: begin
          if (last) begin mode_q <= ST_GAP_IN; cnt_q <= '0; end
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_GAP_IN: begin mode_q <= ST_TEST; cnt_q <= '0; end
        ST_TEST: begin
          if (last) begin mode_q <= ST_GAP_OUT; cnt_q <= '0; end
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: begin mode_q <= ST_NORM; cnt_q <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/rps_avg_buf.sv
module rps_avg_buf #(
  parameter int DW    = 12,
  parameter int LOG2N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] avg_o
);
  localparam int DEPTH = 1 << LOG2N;
  localparam int SW    = DW + LOG2N;

  logic [DW-1:0] mem_q [DEPTH];
  logic [SW-1:0] sum;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem_q[k] <= '0;
      else if (clr_i)   mem_q[k] <= '0;
      else if (push_i)  mem_q[k] <= (k == 0) ? data_i : mem_q[(k == 0) ? 0 : k-1];
    end
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < DEPTH; k++) sum = sum + SW'(mem_q[k]);
  end

  assign avg_o = DW'(sum >> LOG2N);
endmodule

// File: rtl/rps_gate_map.sv
module rps_gate_map
  import rps_pkg::*;
(
  input  logic       en_i,
  input  rps_mode_e  mode_i,
  input  logic       pwm_i,
  output logic [3:0] gate_o
);
  // [0] hi outer, [1] hi inner, [2] lo inner, [3] lo outer
  always_comb begin
    gate_o = 4'b0000;
    if (en_i) begin
      unique case (mode_i)
        ST_NORM: gate_o = {1'b1, ~pwm_i, pwm_i, 1'b1};
        ST_TEST: gate_o = {~pwm_i, 1'b1, 1'b1, pwm_i};
        default: gate_o = 4'b0000;
      endcase
    end
  end
endmodule

// File: rtl/rps_health_mon.sv
module rps_health_mon
  import rps_pkg::*;
#(
  parameter int CUR_W     = 12,
  parameter int CNT_W     = 16,
  parameter int AVG_LOG2  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             pwm_i,
  input  logic             cur_valid_i,
  input  logic [CUR_W-1:0] cur_peak_i,
  input  logic [CNT_W-1:0] test_interval_i,
  input  logic [CNT_W-1:0] test_len_i,
  input  logic [CUR_W-1:0] fault_thr_i,
  input  logic             fault_clr_i,
  output logic [7:0]       gate_o,
  output logic             fault_o,
  output logic             failed_stage_o,
  output logic             active_stage_o
);
  localparam int NSTAGE = 2;

  rps_mode_e        mode;
  logic             test_end;
  logic [CUR_W-1:0] avg_n, avg_t, diff;
  logic [NSTAGE-1:0] dead_q;
  logic             act_q, failed_q, trip;

  rps_sched #(.CNT_W(CNT_W)) i_sched (
    .clk_i, .rst_ni,
    .tick_i     (period_start_i),
    .interval_i (test_interval_i),
    .len_i      (test_len_i),
    .mode_o     (mode),
    .test_end_o (test_end)
  );

  rps_avg_buf #(.DW(CUR_W), .LOG2N(AVG_LOG2)) i_avg_norm (
    .clk_i, .rst_ni,
    .clr_i  (trip),
    .push_i (cur_valid_i && mode == ST_NORM),
    .data_i (cur_peak_i),
    .avg_o  (avg_n)
  );

  rps_avg_buf #(.DW(CUR_W), .LOG2N(AVG_LOG2)) i_avg_test (
    .clk_i, .rst_ni,
    .clr_i  (trip),
    .push_i (cur_valid_i && mode == ST_TEST),
    .data_i (cur_peak_i),
    .avg_o  (avg_t)
  );

  assign diff = (avg_n > avg_t) ? avg_n - avg_t : avg_t - avg_n;
  assign trip = test_end && !dead_q[act_q] && (diff > fault_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_q   <= '0;
      act_q    <= 1'b0;
      failed_q <= 1'b0;
    end else begin
      if (fault_clr_i) dead_q <= '0;
      if (trip) begin
        dead_q[act_q] <= 1'b1;
        act_q         <= ~act_q;
        if (dead_q == '0) failed_q <= act_q;
      end
    end
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    rps_gate_map i_map (
      .en_i   ((act_q == s[0]) && !dead_q[s]),
      .mode_i (mode),
      .pwm_i  (pwm_i),
      .gate_o (gate_o[4*s +: 4])
    );
  end

  assign fault_o        = |dead_q;
  assign failed_stage_o = failed_q;
  assign active_stage_o = act_q;
endmodule

// File: rtl/rps_health_mon_chk.sv
module rps_health_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fault_clr_i,
  input logic [7:0] gate_o,
  input logic       fault_o,
  input logic       failed_stage_o,
  input logic       active_stage_o
);
  a_r10_no_shoot_s0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[0] && gate_o[1] && gate_o[2] && gate_o[3]));
  a_r10_no_shoot_s1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[4] && gate_o[5] && gate_o[6] && gate_o[7]));
  a_r10_one_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|gate_o[7:4], |gate_o[3:0]}));
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !fault_clr_i |=> fault_o);
  a_r8_failed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !fault_clr_i |=> $stable(failed_stage_o));
  a_r8_blank_on_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> gate_o == 8'h00);
  a_r8_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> active_stage_o != $past(active_stage_o));
endmodule

bind rps_health_mon rps_health_mon_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fault_clr_i    (fault_clr_i),
  .gate_o         (gate_o),
  .fault_o        (fault_o),
  .failed_stage_o (failed_stage_o),
  .active_stage_o (active_stage_o)
);

// File: tb/test_rps_health_mon.sv
module test_rps_health_mon;
  logic        clk_i = 0, rst_ni = 0;
  logic        period_start_i = 0, pwm_i = 0, cur_valid_i = 0, fault_clr_i = 0;
  logic [11:0] cur_peak_i = 0, fault_thr_i = 12'd20;
  logic [15:0] test_interval_i = 16'd5, test_len_i = 16'd4;
  logic [7:0]  gate_o;
  logic        fault_o, failed_stage_o, active_stage_o;

  int checks = 0, errors = 0;

  // reference model: 0 norm, 1 gap in, 2 test, 3 gap out
  int m_st = 0, m_cnt = 0, m_act = 0, m_failed = 0;
  bit m_dead [2];
  int bufn [4], buft [4];

  always #2.5 clk_i = ~clk_i;

  rps_health_mon i_rps_health_mon (.*);

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_gates(bit p);
    int g = 0;
    if (!m_dead[m_act]) begin
      if (m_st == 0) g = 1 | (int'(p) << 1) | (int'(!p) << 2) | 8;
      else if (m_st == 2) g = int'(p) | 2 | 4 | (int'(!p) << 3);
    end
    return g << (4 * m_act);
  endfunction

  function automatic int mean4(int b [4]);
    return (b[0] + b[1] + b[2] + b[3]) >> 2;
  endfunction

  task automatic model_edge();
    int d;
    case (m_st)
      0: if (m_cnt == int'(test_interval_i) - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
      1: begin m_st = 2; m_cnt = 0; end
      2: if (m_cnt == int'(test_len_i) - 1) begin
           d = mean4(bufn) - mean4(buft);
           if (d < 0) d = -d;
           if (!m_dead[m_act] && d > int'(fault_thr_i)) begin
             if (!m_dead[0] && !m_dead[1]) m_failed = m_act;
             m_dead[m_act] = 1;
             m_act ^= 1;
             for (int k = 0; k < 4; k++) begin bufn[k] = 0; buft[k] = 0; end
           end
           m_st = 3; m_cnt = 0;
         end else m_cnt++;
      default: begin m_st = 0; m_cnt = 0; end
    endcase
  endtask

  task automatic push(int v);
    if (m_st == 0) begin
      for (int k = 3; k > 0; k--) bufn[k] = bufn[k-1];
      bufn[0] = v;
    end else if (m_st == 2) begin
      for (int k = 3; k > 0; k--) buft[k] = buft[k-1];
      buft[0] = v;
    end
  endtask

  function automatic string gate_tag();
    return (m_st == 0) ? "R2 normal gates" : (m_st == 2) ? "R3 test gates" : "R5 blank gates";
  endfunction

  // rnd: healthy noise; else fixed levels; blank periods always get a huge sample (R6)
  task automatic period(bit rnd, int nv, int tv);
    int v;
    @(negedge clk_i) period_start_i = 1;
    @(posedge clk_i) model_edge();
    @(negedge clk_i) period_start_i = 0; pwm_i = 1;
    @(negedge clk_i) check_eq({gate_tag(), " R4 pwm1"}, gate_o, exp_gates(1));
    pwm_i = 0;
    @(negedge clk_i) check_eq({gate_tag(), " R4 pwm0"}, gate_o, exp_gates(0));
    if (m_st == 1 || m_st == 3) v = 4000;
    else if (rnd) v = 100 + int'($urandom % 8);
    else v = (m_st == 2) ? tv : nv;
    cur_valid_i = 1; cur_peak_i = 12'(v); push(v);
    @(negedge clk_i) cur_valid_i = 0;
    check_eq("R8 R9 fault_o", fault_o, int'(m_dead[0] | m_dead[1]));
    check_eq("R8 active_stage_o", active_stage_o, m_act);
    if (m_dead[0] | m_dead[1]) check_eq("R8 failed_stage_o", failed_stage_o, m_failed);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1; pwm_i = 1;
    @(negedge clk_i);
    check_eq("R1 reset gates", gate_o, 8'h0B);
    check_eq("R1 reset fault", fault_o, 0);
    check_eq("R1 reset active", active_stage_o, 0);

    repeat (30) period(1, 0, 0);                 // healthy random, R4 schedule
    repeat (22) period(0, 100, 120);             // R7 diff == thr, no trip
    check_eq("R7 equal no trip", fault_o, 0);
    while (!m_dead[0]) period(0, 100, 121);      // R7 thr+1 trips, R8 failover
    check_eq("R8 stage0 failed", failed_stage_o, 0);
    check_eq("R8 active now 1", active_stage_o, 1);
    repeat (25) period(1, 0, 0);                 // R9 sticky while stage 1 healthy
    while (!m_dead[1]) period(0, 200, 150);      // stage 1 fails too
    check_eq("R9 both dead gates", gate_o, 0);
    check_eq("R9 first failure kept", failed_stage_o, 0);
    repeat (5) period(1, 0, 0);
    @(negedge clk_i) fault_clr_i = 1;
    @(negedge clk_i) fault_clr_i = 0; m_dead[0] = 0; m_dead[1] = 0;
    check_eq("R9 clear drops fault", fault_o, 0);
    check_eq("R9 clear keeps active", active_stage_o, m_act);
    test_interval_i = 16'd7; test_len_i = 16'd6; fault_thr_i = 12'd10;
    repeat (40) period(1, 0, 0);                 // R4 new lengths, R6 noise
    check_eq("R6 noise no trip", fault_o, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule